// File: doc/BRIEF.md
# Partial-Word Load/Store Byte Merger

This block forms the result of a big-endian partial-word access that straddles an alignment boundary. The surrounding load/store pipeline reads the naturally aligned container, that is a 32-bit word or a 64-bit doubleword at the address with its low bits cleared, and hands it in together with the byte offset taken from the effective address and the current register value. The block shifts and masks the two sources against each other. For a load it returns the new register value. For a store it returns the container image that goes back to the same aligned address.

There are eight operations. Each one is a load or a store, has word or doubleword size, and takes either the "left" part (the bytes from the addressed byte toward the least significant end of the container) or the "right" part (the bytes from the addressed byte toward the most significant end). Transactions arrive on a valid/ready input and leave through one output register on a valid/ready output. A request is accepted in any cycle where `in_valid` and `in_ready` are both high. While a result waits unconsumed, `in_ready` is low, so back-pressure on `out_ready` stalls the upstream stage in the same cycle. No request is dropped and no result is overwritten.

Top module: `partial_word_merger`

## Requirements
- R1: `in_ready` is high whenever the output register is empty or `out_ready` is high. An accepted request appears with `out_valid` high on the next cycle. A result that is not taken (`out_valid` high, `out_ready` low) holds its value and `out_valid` on every following cycle until it is taken.
- R2: `in_op` bit 2 selects store (1) or load (0), bit 1 selects doubleword (1) or word (0), and bit 0 selects right (1) or left (0). Only one of `out_reg_we` and `out_mem_we` is high, and only while `out_valid` is high. The data output that is not being written reads as zero.
- R3: Left word load with offset o = `in_addr[1:0]` and s = 8·o: the low 32 bits are (reg & ~(ones32 << s)) | (mem32 << s). The result is sign-extended from bit 31 to 64 bits.
- R4: Right word load with s = 8·(o XOR 3): the low 32 bits are (reg & ~(ones32 >> s)) | (mem32 >> s). The result is sign-extended from bit 31.
- R5: Left doubleword load with o = `in_addr[2:0]` and s = 8·o gives (reg & ~(ones64 << s)) | (mem << s).
- R6: Right doubleword load with s = 8·(o XOR 7) gives (reg & ~(ones64 >> s)) | (mem >> s).
- R7: Left word store with s = 8·o: `out_mem[31:0]` = (mem32 & ~(ones32 >> s)) | (reg32 >> s), and `out_mem[63:32]` is zero.
- R8: Right word store with s = 8·(o XOR 3): `out_mem[31:0]` = (mem32 & ~(ones32 << s)) | (reg32 << s), and the upper half is zero.
- R9: A doubleword store follows the left rule of R7 or the right rule of R8 at 64-bit width, using s = 8·o for left and s = 8·(o XOR 7) for right.
- R10: For word operations, `in_addr[2]`, `in_mem[63:32]` and `in_reg[63:32]` have no effect on either output.
- R11: A left load at offset 0, or a right load at the highest offset (3 for word, 7 for doubleword), replaces the whole register with the memory value (sign-extended for word).
- R12: While reset is asserted, `out_valid`, `out_reg_we` and `out_mem_we` are low, both data outputs are zero, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when high with `in_valid` |
| in_op | input | 3 | {store, doubleword, right} |
| in_addr | input | 3 | Low effective-address bits (byte offset) |
| in_mem | input | 64 | Aligned container read from memory (word forms use bits 31:0) |
| in_reg | input | 64 | Current register value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_reg | output | 64 | Merged register value for loads, else zero |
| out_reg_we | output | 1 | `out_reg` carries a load result |
| out_mem | output | 64 | Merged container for stores, else zero |
| out_mem_we | output | 1 | `out_mem` carries a store image |

## Verification
The only state inside the block is the output register and its occupancy flag, so a fault there shows at the ports one cycle after the request that exposes it. A lost occupancy bit either drops a stalled result or leaves `in_ready` stuck low. A wrong shift direction or a wrong mask in either lane corrupts particular bytes, and the result carries that corruption in the cycle after acceptance. The bench runs every operation at every offset with several data patterns. It compares each result against a byte-by-byte model of the rules, so a wrong offset complement or swapped mask polarity shows up as a wrong byte at a specific offset.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Decoded operation: {store, dword, right}
  typedef struct packed {
    logic store;
    logic dword;
    logic right;
  } pwm_op_t;

  localparam logic [2:0] OPC_LOAD_LEFT_W   = 3'b000;
  localparam logic [2:0] OPC_LOAD_RIGHT_W  = 3'b001;
  localparam logic [2:0] OPC_LOAD_LEFT_D   = 3'b010;
  localparam logic [2:0] OPC_LOAD_RIGHT_D  = 3'b011;
  localparam logic [2:0] OPC_STORE_LEFT_W  = 3'b100;
  localparam logic [2:0] OPC_STORE_RIGHT_W = 3'b101;
  localparam logic [2:0] OPC_STORE_LEFT_D  = 3'b110;
  localparam logic [2:0] OPC_STORE_RIGHT_D = 3'b111;

endpackage

// File: rtl/pwm_lane.sv
// One shift-and-mask merger of a fixed container width.
module pwm_lane #(
  parameter int LANE_W = 64,
  localparam int OFF_W = $clog2(LANE_W / 8),
  localparam int SH_W  = OFF_W + 3
) (
  input  logic [OFF_W-1:0]  offset_i,
  input  logic              store_i,
  input  logic              right_i,
  input  logic [LANE_W-1:0] mem_i,
  input  logic [LANE_W-1:0] reg_i,
  output logic [LANE_W-1:0] merged_o
);

  logic [OFF_W-1:0]  byte_sh;
  logic [SH_W-1:0]   bit_sh;
  logic              toward_msb;
  logic [LANE_W-1:0] src;
  logic [LANE_W-1:0] keep;
  logic [LANE_W-1:0] mask;
  logic [LANE_W-1:0] moved;

  // Right forms count from the other end of the container.
  assign byte_sh    = right_i ? ~offset_i : offset_i;
  assign bit_sh     = {byte_sh, 3'b000};
  // Left load and right store move data toward the MSB; the other two move it down.
  assign toward_msb = (right_i == store_i);
  assign src        = store_i ? reg_i : mem_i;
  assign keep       = store_i ? mem_i : reg_i;

  always_comb begin
    if (toward_msb) begin
      mask  = {LANE_W{1'b1}} << bit_sh;
      moved = src << bit_sh;
    end else begin
      mask  = {LANE_W{1'b1}} >> bit_sh;
      moved = src >> bit_sh;
    end
  end

  assign merged_o = (keep & ~mask) | moved;

endmodule

// File: rtl/pwm_stage.sv
// Single output register with valid/ready flow control.
module pwm_stage #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_store,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_store
);

  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_store <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
      out_store <= in_store;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/partial_word_merger.sv
module partial_word_merger
  import pwm_pkg::*;
#(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32,
  localparam int WIDE_OFF_W   = $clog2(WIDE_W / 8),
  localparam int NARROW_OFF_W = $clog2(NARROW_W / 8)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [2:0]            in_op,
  input  logic [WIDE_OFF_W-1:0] in_addr,
  input  logic [WIDE_W-1:0]     in_mem,
  input  logic [WIDE_W-1:0]     in_reg,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [WIDE_W-1:0]     out_reg,
  output logic                  out_reg_we,
  output logic [WIDE_W-1:0]     out_mem,
  output logic                  out_mem_we
);

  localparam int N_LANES = 2;
  localparam int EXT_W   = WIDE_W - NARROW_W;

  pwm_op_t           op;
  logic [WIDE_W-1:0] lane_res [N_LANES];
  logic [WIDE_W-1:0] merged;
  logic [WIDE_W-1:0] held;
  logic              held_store;

  assign op = pwm_op_t'(in_op);

  // Lane 0 serves word forms, lane 1 doubleword forms.
  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    localparam int LW   = (g == 0) ? NARROW_W : WIDE_W;
    localparam int LOFF = (g == 0) ? NARROW_OFF_W : WIDE_OFF_W;
    logic [LW-1:0] res;

    pwm_lane #(.LANE_W(LW)) u_lane (
      .offset_i (in_addr[LOFF-1:0]),
      .store_i  (op.store),
      .right_i  (op.right),
      .mem_i    (in_mem[LW-1:0]),
      .reg_i    (in_reg[LW-1:0]),
      .merged_o (res)
    );

    assign lane_res[g] = WIDE_W'(res);
  end

  always_comb begin
    if (op.dword) begin
      merged = lane_res[1];
    end else if (op.store) begin
      merged = {{EXT_W{1'b0}}, lane_res[0][NARROW_W-1:0]};
    end else begin
      merged = {{EXT_W{lane_res[0][NARROW_W-1]}}, lane_res[0][NARROW_W-1:0]};
    end
  end

  pwm_stage #(.DATA_W(WIDE_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (merged),
    .in_store  (op.store),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (held),
    .out_store (held_store)
  );

  assign out_reg_we = out_valid && !held_store;
  assign out_mem_we = out_valid && held_store;
  assign out_reg    = out_reg_we ? held : '0;
  assign out_mem    = out_mem_we ? held : '0;

endmodule

// File: rtl/pwm_checker.sv
module pwm_checker #(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32,
  localparam int WIDE_OFF_W = $clog2(WIDE_W / 8)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [2:0]            in_op,
  input logic [WIDE_OFF_W-1:0] in_addr,
  input logic [WIDE_W-1:0]     in_mem,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [WIDE_W-1:0]     out_reg,
  input logic                  out_reg_we,
  input logic [WIDE_W-1:0]     out_mem,
  input logic                  out_mem_we
);

  localparam int EXT_W = WIDE_W - NARROW_W;

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R1

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R1

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_reg) && $stable(out_mem))); // R1

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({out_reg_we, out_mem_we}) == (out_valid ? 1 : 0)); // R2

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_mem_we |-> out_mem == '0) and (!out_reg_we |-> out_reg == '0)); // R2

  AST_WORD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op[2:1] == 2'b00)
      |=> out_reg[WIDE_W-1:NARROW_W] == {EXT_W{out_reg[NARROW_W-1]}}); // R3

  AST_LEFT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 3'b010 && in_addr == '0)
      |=> out_reg == $past(in_mem)); // R11

  AST_RIGHT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == 3'b011 && in_addr == '1)
      |=> out_reg == $past(in_mem)); // R11

endmodule

bind partial_word_merger pwm_checker #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_pwm_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .in_addr    (in_addr),
  .in_mem     (in_mem),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_reg    (out_reg),
  .out_reg_we (out_reg_we),
  .out_mem    (out_mem),
  .out_mem_we (out_mem_we)
);

// File: tb/test_partial_word_merger.sv
`timescale 1ns/1ps
module test_partial_word_merger;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [2:0]  in_addr = '0;
  logic [63:0] in_mem = '0;
  logic [63:0] in_reg = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_reg;
  logic        out_reg_we;
  logic [63:0] out_mem;
  logic        out_mem_we;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  partial_word_merger i_partial_word_merger (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_addr(in_addr), .in_mem(in_mem), .in_reg(in_reg),
    .out_valid(out_valid), .out_ready(out_ready), .out_reg(out_reg),
    .out_reg_we(out_reg_we), .out_mem(out_mem), .out_mem_we(out_mem_we)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Byte-by-byte model; byte 0 is the least significant byte.
  function automatic logic [63:0] model(input logic [2:0] op, input logic [2:0] a,
                                        input logic [63:0] m, input logic [63:0] r);
    int n = op[1] ? 8 : 4;
    int o = op[1] ? int'(a) : int'(a[1:0]);
    int s = n - 1 - o;
    logic [63:0] res = '0;
    for (int i = 0; i < n; i++) begin
      res[8*i +: 8] = op[2] ? m[8*i +: 8] : r[8*i +: 8];
      case ({op[2], op[0]})
        2'b00: if (i >= o)     res[8*i +: 8] = m[8*(i-o) +: 8];
        2'b01: if (i < n - s)  res[8*i +: 8] = m[8*(i+s) +: 8];
        2'b10: if (i < n - o)  res[8*i +: 8] = r[8*(i+o) +: 8];
        default: if (i >= s)   res[8*i +: 8] = r[8*(i-s) +: 8];
      endcase
    end
    if (!op[1] && !op[2]) res[63:32] = {32{res[31]}};
    return res;
  endfunction

  function automatic string tag_of(input logic [2:0] op, input logic [2:0] a);
    if (!op[2] && ((!op[0] && (op[1] ? a == 0 : a[1:0] == 0)) ||
                   (op[0] && (op[1] ? a == 7 : a[1:0] == 3)))) return "R11";
    if (!op[1] && a[2]) return "R10";
    case (op)
      3'b000: return "R3";
      3'b001: return "R4";
      3'b010: return "R5";
      3'b011: return "R6";
      3'b100: return "R7";
      3'b101: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Drive at a negedge, accepted at the next posedge, checked at the following negedge.
  task automatic run_one(input logic [2:0] op, input logic [2:0] a,
                         input logic [63:0] m, input logic [63:0] r);
    logic [63:0] exp;
    in_op = op; in_addr = a; in_mem = m; in_reg = r; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp = model(op, a, m, r);
    if (op[2]) begin
      chk(tag_of(op, a), out_mem, exp);
      chk("R2 other output zero", out_reg, 64'd0);
    end else begin
      chk(tag_of(op, a), out_reg, exp);
      chk("R2 other output zero", out_mem, 64'd0);
    end
    chk("R2 write flags", {62'd0, out_reg_we, out_mem_we}, {62'd0, !op[2], op[2]});
  endtask

  initial begin
    logic [63:0] pm [6];
    logic [63:0] pr [6];
    pm[0] = 64'h0123456789ABCDEF; pr[0] = 64'hFEDCBA9876543210;
    pm[1] = 64'h8899AABBCCDDEEFF; pr[1] = 64'h1122334455667788;
    pm[2] = 64'hFFFFFFFFFFFFFFFF; pr[2] = 64'h0000000000000000;
    pm[3] = 64'h0000000000000000; pr[3] = 64'hFFFFFFFFFFFFFFFF;
    pm[4] = 64'h5A5A5A5A7F80C3E1; pr[4] = 64'hA5A5A5A5803C1E96;
    pm[5] = 64'hDEADBEEF00C0FFEE; pr[5] = 64'h13579BDF2468ACE0;

    repeat (3) @(negedge clk);
    // R12: reset values
    chk("R12 out_valid", {63'd0, out_valid}, 64'd0);
    chk("R12 out_reg", out_reg, 64'd0);
    chk("R12 out_mem", out_mem, 64'd0);
    chk("R12 flags/in_ready", {61'd0, out_reg_we, out_mem_we, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int p = 0; p < 6; p++)
      for (int op = 0; op < 8; op++)
        for (int a = 0; a < 8; a++)
          run_one(3'(op), 3'(a), pm[p], pr[p]);

    @(negedge clk);
    chk("R1 idle after drain", {63'd0, out_valid}, 64'd0);

    // R1: back-pressure
    out_ready = 1'b0;
    in_op = 3'b010; in_addr = 3'd3; in_mem = pm[0]; in_reg = pr[0]; in_valid = 1'b1;
    @(negedge clk);
    chk("R1 valid after accept", {63'd0, out_valid}, 64'd1);
    chk("R1 ready low while stalled", {63'd0, in_ready}, 64'd0);
    in_op = 3'b001; in_addr = 3'd1; in_mem = pm[1]; in_reg = pr[1];
    @(negedge clk);
    chk("R1 held while stalled", out_reg, model(3'b010, 3'd3, pm[0], pr[0]));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 next after release", out_reg, model(3'b001, 3'd1, pm[1], pr[1]));
    chk("R1 valid kept for next", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    chk("R1 drained", {63'd0, out_valid}, 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule